// File: doc/BRIEF.md
# Bus Transaction Hang and Retry Monitor

This block watches a multi-phase bus transaction from the side and reports when it stalls or when it retries too often. On the receive side a transaction first obtains a reservation, then accepts a high data packet, then a low data packet. On the send side an operation first tries to obtain a reservation and then runs its later phases, and every phase may be retried. The protocol engine that actually runs the transaction is not part of this block. It only sends one-cycle strobes for each phase event and each retry.

Timeouts are measured against a coarse hang pulse of about 1 µs. The pulse is slowed down by a programmable 5-bit divisor, with one divisor for the receive side and one for the send side. A wait is declared hung once two divided pulses have arrived during that wait. Because of this, the time to a timeout lies between one and two divided periods. Send retries are counted against an 8-bit threshold. Overcommit retries can be included in that count or left out, as chosen by a mode bit. Every finding is latched into a sticky status bit that stays set until software-side logic pulses a clear input.

Top module: `xact_hang_mon`

## Requirements
- R1: After a synchronous active-low reset, all four status outputs are 0, both sides are idle, and the divider and retry counts are zero.
- R2: A divisor of 0 produces no divided pulses, so that side can never time out. A divisor N in 1..31 produces one divided pulse on every N-th hang pulse. The divider counts hang pulses continuously from reset, and a pulse is emitted when the count has reached N-1 or more.
- R3: After a reservation grant, the receive side waits for a high packet. If a second divided pulse arrives during that wait, `rx_hi_timeout` is set at the next clock edge.
- R4: After a high packet is accepted, the receive side waits for a low packet. If a second divided pulse arrives during that wait, `rx_lo_timeout` is set.
- R5: After `tx_start`, the send side waits for a reservation. If a second divided pulse arrives before `tx_resv_ack`, `tx_resv_timeout` is set.
- R6: The divided-pulse count for a wait is cleared when the awaited event arrives, when a wait is restarted, and when that side returns to idle. If the awaited event arrives in the same cycle as the second divided pulse, no timeout is raised.
- R7: While a send operation is active, each `tx_retry` adds one to a retry count. When an increment makes the count greater than a non-zero threshold, `tx_drop` is set and the operation ends. A threshold of 0 never drops.
- R8: `tx_ovc_retry` adds one to the retry count only while `cfg_ovc_count` is 1. A normal retry and an overcommit retry in the same cycle add two.
- R9: The retry count is cleared by `tx_start`, by `tx_end` and by a drop. A drop returns the send side to idle. Retries that arrive while the send side is idle are not counted.
- R10: Every status bit stays set until `status_clr` is 1. If a set condition and the clear arrive in the same cycle, the bit is set.
- R11: Phase events that arrive out of order are ignored. A high or low packet while receive is idle, a grant during a receive wait, and `tx_resv_ack` outside the reservation wait do not change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hang_pulse | input | 1 | One-cycle coarse time pulse (about 1 µs) |
| cfg_rx_div | input | 5 | Receive-side hang pulse divisor, 0 disables |
| cfg_tx_div | input | 5 | Send-side hang pulse divisor, 0 disables |
| cfg_retry_thr | input | 8 | Send retry limit, 0 means no limit |
| cfg_ovc_count | input | 1 | 1 counts overcommit retries toward the limit |
| rx_resv_grant | input | 1 | Receive reservation granted strobe |
| rx_hi_accept | input | 1 | High data packet accepted strobe |
| rx_lo_accept | input | 1 | Low data packet accepted strobe |
| rx_abort | input | 1 | Receive transaction abandoned, back to idle |
| tx_start | input | 1 | New send operation, reservation attempt begins |
| tx_resv_ack | input | 1 | Send reservation obtained strobe |
| tx_end | input | 1 | Send operation finished |
| tx_retry | input | 1 | Send retry strobe |
| tx_ovc_retry | input | 1 | Overcommit retry strobe |
| status_clr | input | 1 | Clears all sticky status bits |
| rx_hi_timeout | output | 1 | Sticky: high packet wait hung |
| rx_lo_timeout | output | 1 | Sticky: low packet wait hung |
| tx_resv_timeout | output | 1 | Sticky: send reservation wait hung |
| tx_drop | output | 1 | Sticky: send operation dropped on retry limit |

## Verification
Every status result is due exactly one clock edge after the cycle in which the deciding strobe or divided pulse is presented. This holds for the second divided pulse of a wait, for the retry that exceeds the threshold, and for a clear. The bench drives inputs on the falling edge and runs its reference model directly after the rising edge, using the same input values. It then compares all four outputs on the next falling edge, so each result is checked in the cycle it first becomes due. The directed cases read the outputs at that same point, right after the stimulus that decides them.

// File: rtl/xhm_pkg.sv
// Shared types for the transaction hang and retry monitor.
package xhm_pkg;
    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_WAIT_HI = 2'd1,
        RX_WAIT_LO = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_RESV = 2'd1,
        TX_BUSY = 2'd2
    } tx_state_e;
endpackage

// File: rtl/xhm_pulse_div.sv
// Hang pulse divider.
// Counts hang pulses without stopping. When the count has reached div_i-1
// or more, the current hang pulse is passed through as tick_o and the count
// wraps to zero. A divisor of zero holds the count at zero and never ticks.
// Assumes hang_pulse_i is a single-cycle strobe.
module xhm_pulse_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hang_pulse_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // Decide whether this hang pulse completes a divided period.
    always_comb begin
        at_end = (div_i != '0) && (cnt_q >= div_i - ONE);
        tick_o = hang_pulse_i && at_end;
    end

    // Advance or wrap the hang pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (div_i == '0)      cnt_q <= '0;
        else if (hang_pulse_i)     cnt_q <= at_end ? '0 : cnt_q + ONE;
    end

    // R2
    wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
    // R2
    disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/xhm_wait_timer.sv
// Wait watchdog for one phase.
// Counts divided ticks while waiting_i is high, saturating at two. hang_o
// pulses on the tick that brings the count to two. restart_i (the awaited
// event, a restart, or a return to idle) clears the count and masks hang_o.
module xhm_wait_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic hang_o
);
    logic [1:0] cnt_q;

    // Flag the second tick seen in an undisturbed wait.
    always_comb hang_o = waiting_i && !restart_i && tick_i && (cnt_q == 2'd1);

    // Count ticks in the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= 2'd0;
        else if (restart_i || !waiting_i) cnt_q <= 2'd0;
        else if (tick_i && cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
    end

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == 2'd0));
    // R3
    hang_on_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang_o |=> (cnt_q == 2'd2));
endmodule

// File: rtl/xhm_retry_ctr.sv
// Send retry counter.
// While active_i is high, adds the normal retry plus (when the mode bit
// allows) the overcommit retry, saturating at the counter maximum.
// exceed_o flags an increment that lifts the count above a non-zero limit.
// clear_i has priority over counting.
module xhm_retry_ctr #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             clear_i,
    input  logic             retry_i,
    input  logic             ovc_retry_i,
    input  logic             ovc_mode_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             exceed_o
);
    localparam int CNT_W = THR_W + 1;
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sum_sat;

    // Form this cycle's increment and the saturated new count.
    always_comb begin
        inc      = {1'b0, retry_i} + {1'b0, ovc_retry_i && ovc_mode_i};
        sum      = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
        sum_sat  = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
        exceed_o = active_i && (inc != 2'd0) && (thr_i != '0)
                   && (sum > {2'b00, thr_i});
    end

    // Hold the retry count of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (active_i) cnt_q <= sum_sat;
    end

    // R9
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/xact_hang_mon.sv
// Transaction hang and retry monitor, top level.
// Tracks the receive phases (reservation -> high packet -> low packet) and the
// send reservation phase, times each wait with a divided hang pulse, counts
// send retries against a limit and latches four sticky status bits.
// Assumes all event inputs are single-cycle strobes from the protocol engine.
module xact_hang_mon #(
    parameter int DIV_W = 5,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hang_pulse,
    input  logic [DIV_W-1:0] cfg_rx_div,
    input  logic [DIV_W-1:0] cfg_tx_div,
    input  logic [THR_W-1:0] cfg_retry_thr,
    input  logic             cfg_ovc_count,
    input  logic             rx_resv_grant,
    input  logic             rx_hi_accept,
    input  logic             rx_lo_accept,
    input  logic             rx_abort,
    input  logic             tx_start,
    input  logic             tx_resv_ack,
    input  logic             tx_end,
    input  logic             tx_retry,
    input  logic             tx_ovc_retry,
    input  logic             status_clr,
    output logic             rx_hi_timeout,
    output logic             rx_lo_timeout,
    output logic             tx_resv_timeout,
    output logic             tx_drop
);
    import xhm_pkg::*;

    localparam int SIDES = 2;   // index 0: receive, index 1: send

    rx_state_e rx_q, rx_d;
    tx_state_e tx_q, tx_d;

    logic [SIDES-1:0][DIV_W-1:0] side_div;
    logic [SIDES-1:0]            side_tick;
    logic [SIDES-1:0]            side_wait;
    logic [SIDES-1:0]            side_restart;
    logic [SIDES-1:0]            side_hang;
    logic                        retry_exceed;
    logic                        drop_set;
    logic                        retry_clear;

    // Route each side's divisor to its divider.
    always_comb begin
        side_div[0] = cfg_rx_div;
        side_div[1] = cfg_tx_div;
    end

    // One divider and one wait timer per side.
    for (genvar g = 0; g < SIDES; g++) begin : g_side
        xhm_pulse_div #(.DIV_W(DIV_W)) u_div (
            .clk          (clk),
            .rst_n        (rst_n),
            .hang_pulse_i (hang_pulse),
            .div_i        (side_div[g]),
            .tick_o       (side_tick[g])
        );
        xhm_wait_timer u_wait (
            .clk       (clk),
            .rst_n     (rst_n),
            .waiting_i (side_wait[g]),
            .restart_i (side_restart[g]),
            .tick_i    (side_tick[g]),
            .hang_o    (side_hang[g])
        );
    end

    // Receive phase sequencing; out-of-order events leave the state alone.
    always_comb begin
        rx_d = rx_q;
        unique case (rx_q)
            RX_IDLE:    if (rx_resv_grant) rx_d = RX_WAIT_HI;
            RX_WAIT_HI: if (rx_abort) rx_d = RX_IDLE;
                        else if (rx_hi_accept) rx_d = RX_WAIT_LO;
            RX_WAIT_LO: if (rx_abort || rx_lo_accept) rx_d = RX_IDLE;
            default:    rx_d = RX_IDLE;
        endcase
    end

    // Send phase sequencing: start, then end, then drop take priority.
    always_comb begin
        tx_d = tx_q;
        if (tx_start)                          tx_d = TX_RESV;
        else if (tx_end)                       tx_d = TX_IDLE;
        else if (retry_exceed)                 tx_d = TX_IDLE;
        else if (tx_q == TX_RESV && tx_resv_ack) tx_d = TX_BUSY;
    end

    // Tell each wait timer when it is waiting and when to restart.
    always_comb begin
        side_wait[0]    = (rx_q != RX_IDLE);
        side_restart[0] = (rx_d != rx_q);
        side_wait[1]    = (tx_q == TX_RESV);
        side_restart[1] = (tx_d != tx_q) || tx_start;
        drop_set        = retry_exceed && !tx_start && !tx_end;
        retry_clear     = tx_start || tx_end || retry_exceed;
    end

    xhm_retry_ctr #(.THR_W(THR_W)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (tx_q != TX_IDLE),
        .clear_i     (retry_clear),
        .retry_i     (tx_retry),
        .ovc_retry_i (tx_ovc_retry),
        .ovc_mode_i  (cfg_ovc_count),
        .thr_i       (cfg_retry_thr),
        .exceed_o    (retry_exceed)
    );

    // Phase state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= RX_IDLE;
            tx_q <= TX_IDLE;
        end else begin
            rx_q <= rx_d;
            tx_q <= tx_d;
        end
    end

    // Sticky status: a set beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hi_timeout   <= 1'b0;
            rx_lo_timeout   <= 1'b0;
            tx_resv_timeout <= 1'b0;
            tx_drop         <= 1'b0;
        end else begin
            rx_hi_timeout   <= (side_hang[0] && rx_q == RX_WAIT_HI) || (rx_hi_timeout && !status_clr);
            rx_lo_timeout   <= (side_hang[0] && rx_q == RX_WAIT_LO) || (rx_lo_timeout && !status_clr);
            tx_resv_timeout <= side_hang[1] || (tx_resv_timeout && !status_clr);
            tx_drop         <= drop_set || (tx_drop && !status_clr);
        end
    end

    // R3
    hi_timeout_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_hi_timeout) |-> ($past(rx_q) == RX_WAIT_HI));
    // R4
    lo_timeout_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_lo_timeout) |-> ($past(rx_q) == RX_WAIT_LO));
    // R10
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drop && !status_clr) |=> tx_drop);
    // R7
    drop_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_drop) |-> ($past(cfg_retry_thr) != '0));
    // R9
    drop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_drop) |-> (tx_q == TX_IDLE));
endmodule

// File: tb/xact_hang_mon_test.sv
module xact_hang_mon_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hang_pulse = 1'b0;
    logic [4:0] cfg_rx_div = 5'd1, cfg_tx_div = 5'd1;
    logic [7:0] cfg_retry_thr = 8'd0;
    logic cfg_ovc_count = 1'b0;
    logic rx_resv_grant = 0, rx_hi_accept = 0, rx_lo_accept = 0, rx_abort = 0;
    logic tx_start = 0, tx_resv_ack = 0, tx_end = 0, tx_retry = 0, tx_ovc_retry = 0;
    logic status_clr = 0;
    logic rx_hi_timeout, rx_lo_timeout, tx_resv_timeout, tx_drop;

    int compared = 0, mismatched = 0, cycles = 0;

    // Reference model state
    int m_dcnt[2], m_tcnt[2], m_rcnt, m_rx, m_tx;
    bit e_hi, e_lo, e_resv, e_drop;

    xact_hang_mon uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Spec-level model of one clock edge, using the inputs the design sampled.
    task automatic model_step();
        int d[2];
        bit tick[2], wt[2], rs[2], hg[2], exceed, act;
        int inc, sum, rxn, txn;
        if (!rst_n) begin
            m_dcnt = '{0, 0}; m_tcnt = '{0, 0}; m_rcnt = 0; m_rx = 0; m_tx = 0;
            {e_hi, e_lo, e_resv, e_drop} = 4'b0;
            return;
        end
        d[0] = cfg_rx_div; d[1] = cfg_tx_div;
        for (int s = 0; s < 2; s++)
            tick[s] = hang_pulse && d[s] != 0 && m_dcnt[s] >= d[s] - 1;
        act = (m_tx != 0);
        inc = tx_retry + (tx_ovc_retry && cfg_ovc_count);
        sum = m_rcnt + inc;
        exceed = act && inc != 0 && cfg_retry_thr != 0 && sum > cfg_retry_thr;
        rxn = m_rx;
        case (m_rx)
            0: if (rx_resv_grant) rxn = 1;
            1: if (rx_abort) rxn = 0; else if (rx_hi_accept) rxn = 2;
            default: if (rx_abort || rx_lo_accept) rxn = 0;
        endcase
        txn = m_tx;
        if (tx_start) txn = 1;
        else if (tx_end || exceed) txn = 0;
        else if (m_tx == 1 && tx_resv_ack) txn = 2;
        wt[0] = (m_rx != 0); rs[0] = (rxn != m_rx);
        wt[1] = (m_tx == 1); rs[1] = (txn != m_tx) || tx_start;
        for (int s = 0; s < 2; s++) begin
            hg[s] = wt[s] && !rs[s] && tick[s] && m_tcnt[s] == 1;
            if (rs[s] || !wt[s]) m_tcnt[s] = 0;
            else if (tick[s] && m_tcnt[s] < 2) m_tcnt[s]++;
            if (d[s] == 0) m_dcnt[s] = 0;
            else if (hang_pulse) m_dcnt[s] = tick[s] ? 0 : m_dcnt[s] + 1;
        end
        e_hi   = (hg[0] && m_rx == 1) || (e_hi && !status_clr);
        e_lo   = (hg[0] && m_rx == 2) || (e_lo && !status_clr);
        e_resv = hg[1] || (e_resv && !status_clr);
        e_drop = (exceed && !tx_start && !tx_end) || (e_drop && !status_clr);
        if (tx_start || tx_end || exceed) m_rcnt = 0;
        else if (act) m_rcnt = (sum > 511) ? 511 : sum;
        m_rx = rxn; m_tx = txn;
    endtask

    // One clock: design and model advance, outputs compared mid-cycle.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(rx_hi_timeout, e_hi, "R3", "rx_hi_timeout");
        chk(rx_lo_timeout, e_lo, "R4", "rx_lo_timeout");
        chk(tx_resv_timeout, e_resv, "R5", "tx_resv_timeout");
        chk(tx_drop, e_drop, "R7", "tx_drop");
        {hang_pulse, rx_resv_grant, rx_hi_accept, rx_lo_accept, rx_abort} = '0;
        {tx_start, tx_resv_ack, tx_end, tx_retry, tx_ovc_retry, status_clr} = '0;
    endtask

    task automatic hp(input int n);
        for (int i = 0; i < n; i++) begin hang_pulse = 1; cyc(); end
    endtask

    task automatic clear_all();
        rx_abort = 1; tx_end = 1; status_clr = 1; cyc();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk(rx_hi_timeout | rx_lo_timeout | tx_resv_timeout | tx_drop, 1'b0, "R1", "status after reset");

        // R3: divisor 1, two pulses in high wait
        rx_resv_grant = 1; cyc();
        hp(1); chk(rx_hi_timeout, 0, "R3", "after one divided pulse");
        hp(1); chk(rx_hi_timeout, 1, "R3", "after two divided pulses");
        clear_all();

        // R6: awaited event on the second pulse masks it; count restarts
        rx_resv_grant = 1; cyc();
        hp(1);
        hang_pulse = 1; rx_hi_accept = 1; cyc();
        hp(1);
        chk(rx_hi_timeout, 0, "R6", "hi wait with accept on second pulse");
        chk(rx_lo_timeout, 0, "R6", "lo wait after one pulse");
        // R4: the next pulse is the second one in the low wait
        hp(1); chk(rx_lo_timeout, 1, "R4", "lo wait after two pulses");
        clear_all();

        // R10: a set in the same cycle as a clear wins; the bit stays set
        rx_resv_grant = 1; cyc(); hp(1);
        hang_pulse = 1; status_clr = 1; cyc();
        chk(rx_hi_timeout, 1, "R10", "set with clear same cycle");
        repeat (5) cyc();
        chk(rx_hi_timeout, 1, "R10", "sticky hold");
        status_clr = 1; cyc();
        chk(rx_hi_timeout, 0, "R10", "cleared");
        clear_all();

        // R2: divisor 0 never times out
        cfg_rx_div = 0; rx_resv_grant = 1; cyc(); hp(12);
        chk(rx_hi_timeout, 0, "R2", "divisor 0 disables");
        clear_all();

        // R5: send reservation wait
        tx_start = 1; cyc(); hp(2);
        chk(tx_resv_timeout, 1, "R5", "reservation wait hung");
        clear_all();

        // R11: out-of-order events ignored
        cfg_rx_div = 1;
        rx_hi_accept = 1; cyc(); hp(3);
        chk(rx_lo_timeout, 0, "R11", "hi accept while idle");
        tx_resv_ack = 1; cyc(); tx_start = 1; cyc(); hp(2);
        chk(tx_resv_timeout, 1, "R11", "stray ack before start ignored");
        clear_all();

        // R7: limit 3, drop on the fourth retry
        cfg_retry_thr = 3; tx_start = 1; cyc();
        repeat (3) begin tx_retry = 1; cyc(); end
        chk(tx_drop, 0, "R7", "three retries at limit 3");
        tx_retry = 1; cyc();
        chk(tx_drop, 1, "R7", "fourth retry exceeds");
        // R9: after a drop, retries are not counted until a new start
        status_clr = 1; cyc();
        repeat (6) begin tx_retry = 1; cyc(); end
        chk(tx_drop, 0, "R9", "retries while idle after drop");
        clear_all();

        // R7: limit 0 never drops
        cfg_retry_thr = 0; tx_start = 1; cyc();
        repeat (300) begin tx_retry = 1; cyc(); end
        chk(tx_drop, 0, "R7", "no limit");
        clear_all();

        // R8: overcommit retries ignored unless mode set; two in one cycle
        cfg_retry_thr = 2; cfg_ovc_count = 0; tx_start = 1; cyc();
        repeat (5) begin tx_ovc_retry = 1; cyc(); end
        chk(tx_drop, 0, "R8", "overcommit not counted");
        cfg_ovc_count = 1; tx_start = 1; cyc();
        tx_retry = 1; tx_ovc_retry = 1; cyc();
        chk(tx_drop, 0, "R8", "count two at limit 2");
        tx_ovc_retry = 1; cyc();
        chk(tx_drop, 1, "R8", "overcommit exceeds");
        clear_all();

        // R9: restart clears the retry count
        cfg_ovc_count = 0; tx_start = 1; cyc();
        repeat (2) begin tx_retry = 1; cyc(); end
        tx_start = 1; cyc();
        repeat (2) begin tx_retry = 1; cyc(); end
        chk(tx_drop, 0, "R9", "count cleared by restart");
        clear_all();

        // Random traffic against the model (R2..R11)
        for (int n = 0; n < 6000; n++) begin
            int r;
            if (n % 500 == 0) begin
                cfg_rx_div = 5'($urandom % 6);
                cfg_tx_div = 5'($urandom % 6);
                cfg_retry_thr = 8'($urandom % 6);
                cfg_ovc_count = 1'($urandom % 2);
            end
            hang_pulse = ($urandom % 3 == 0);
            r = $urandom % 20;
            case (r)
                0, 1: rx_resv_grant = 1;
                2, 3: rx_hi_accept = 1;
                4:    rx_lo_accept = 1;
                5:    rx_abort = 1;
                6:    tx_start = 1;
                7, 8: tx_resv_ack = 1;
                9:    tx_end = 1;
                10, 11: tx_retry = 1;
                12:   tx_ovc_retry = 1;
                13:   begin tx_retry = 1; tx_ovc_retry = 1; end
                default: ;
            endcase
            status_clr = ($urandom % 40 == 0);
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule